// File: doc/BRIEF.md
# Interconnect Layer Flow-Control Arbiter

This block governs a single layer of an on-chip interconnect, for example the layer that carries requests or the layer that carries responses. In any cycle one source port may try to pass a packet to a numbered destination. The arbiter grants the try in the same cycle. When the try is granted, the requester also reports whether the destination took the packet, and the layer is then held occupied for a caller-supplied number of cycles. Address decoding and payload transport belong to the surrounding logic.

A source that is turned away because the layer is occupied is appended to an ordered queue of source IDs. A source appears in that queue at most once. When the layer frees up, the source at the head of the queue is offered a retry, and it must resend in the cycle the offer is visible. When a destination refuses a granted packet, the arbiter notes the source against that destination. The source is then held back from retries until that destination signals that it can take traffic again. A drain flag tells the surrounding logic whether the layer is quiet.

Top module: `layer_arbiter`

## Requirements
- R1: Under synchronous reset the layer enters IDLE (`lyr_state` encoding 0 = IDLE, 1 = BUSY, 2 = RETRY), with `rty_vld` low and `drain` low.
- R2: In IDLE, a try is granted in the same cycle. The layer is then BUSY for exactly `req_hold` cycles, where a hold of 0 counts as 1. If no source is queued, it then returns to IDLE.
- R3: A try made while the layer is BUSY is refused, and its source is queued. When the occupation ends with the queue non-empty and the head source not waiting on a destination, the layer enters RETRY with `rty_vld` high and `rty_src` equal to the head source.
- R4: In RETRY, a try from `rty_src` is granted. A successful send removes that source from the head of the queue and occupies the layer for its hold time. Queued sources are then offered retries in the order in which they were refused.
- R5: In RETRY, a try from any source other than `rty_src` is refused and queued. If the retried source does not send in that cycle, the layer spends one cycle in BUSY and then offers the retry to the same head source again.
- R6: A source that is refused several times while already queued keeps a single queue entry, so it receives only one retry offer.
- R7: A granted send with `req_dst_ok` low occupies the layer for its hold time and records the source against destination `req_dst`. The source is queued unless it is already at the head of the queue. While that record stands, the end of occupation returns the layer to IDLE without offering the source a retry.
- R8: A destination retry on `peer_rty_dst` is honoured only if a source is recorded against that destination. Honouring it clears the record, and from IDLE it moves the layer to RETRY, offering the head source. A destination retry with no record, or a repeated one after the record has been cleared, leaves the layer unchanged.
- R9: `drain` is high while the layer is BUSY or RETRY, and low while it is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | A source is trying to send this cycle |
| req_src | input | SW | ID of the trying source |
| req_dst | input | DW | Destination the packet is aimed at |
| req_dst_ok | input | 1 | The destination accepts the packet (meaningful when granted) |
| req_hold | input | TW | Cycles to occupy the layer after a granted try |
| req_grant | output | 1 | The try is accepted by the layer (same cycle) |
| peer_rty_vld | input | 1 | A destination signals that it can take traffic again |
| peer_rty_dst | input | DW | ID of the destination that is signalling |
| rty_vld | output | 1 | A retry offer is open to `rty_src` |
| rty_src | output | SW | Source being offered the retry |
| lyr_state | output | 2 | Layer state: 0 IDLE, 1 BUSY, 2 RETRY |
| drain | output | 1 | Layer is not idle |

## Verification
The assertions assume at most one try per cycle and in-range source and destination IDs. The bench keeps within these limits by driving single, directed tries. The assertions also assume that a destination only issues a retry after refusing a packet. Inputs are changed on the falling edge. Each scenario walks the state sequence cycle by cycle and checks the grant in the same cycle, and it never presents a try and a destination retry together.

// File: rtl/layer_arb_pkg.sv
package layer_arb_pkg;

    typedef enum logic [1:0] {
        LYR_IDLE  = 2'd0,
        LYR_BUSY  = 2'd1,
        LYR_RETRY = 2'd2
    } lyr_state_e;

    // State taken when an occupation window ends.
    function automatic lyr_state_e lyr_on_release(input logic q_empty, input logic head_blocked);
        return (q_empty || head_blocked) ? LYR_IDLE : LYR_RETRY;
    endfunction

endpackage

// File: rtl/lyr_rtry_fifo.sv
module lyr_rtry_fifo #(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [SW-1:0] push_id,
    input  logic          pop,
    output logic [SW-1:0] head,
    output logic          empty
);
    localparam int CW = $clog2(NSRC + 1);

    logic [SW-1:0] slot_q [NSRC];
    logic [SW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic [NSRC-1:0] in_q;
    logic do_push;

    function automatic logic [SW-1:0] wrap_inc(input logic [SW-1:0] p);
        return (p == SW'(NSRC - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !in_q[push_id] && (cnt_q < CW'(NSRC));
    assign head    = slot_q[rd_q];
    assign empty   = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            in_q  <= '0;
            for (int i = 0; i < NSRC; i++) slot_q[i] <= '0;
        end else begin
            if (pop && !empty) begin
                rd_q <= wrap_inc(rd_q);
                in_q[slot_q[rd_q]] <= 1'b0;
            end
            if (do_push) begin
                slot_q[wr_q]  <= push_id;
                wr_q          <= wrap_inc(wr_q);
                in_q[push_id] <= 1'b1;
            end
            cnt_q <= cnt_q + CW'(do_push) - CW'(pop && !empty);
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push && !in_q[push_id] |-> cnt_q < CW'(NSRC));
    p_dedup_r6: assert property (@(posedge clk) disable iff (rst)
        (push && in_q[push_id] && !pop) |=> $stable(cnt_q));
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/lyr_hold_timer.sv
module lyr_hold_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    assign expire = run && (cnt_q <= TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? TW'(1) : load_val;
        end else if (run && cnt_q > TW'(1)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    p_load_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q != '0);

endmodule

// File: rtl/lyr_peer_tbl.sv
module lyr_peer_tbl #(
    parameter int NDST = 4,
    parameter int SW   = 2,
    parameter int DW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic [DW-1:0] set_dst,
    input  logic [SW-1:0] set_src,
    input  logic          clr,
    input  logic [DW-1:0] clr_dst,
    input  logic [DW-1:0] look_dst,
    output logic          look_hit,
    input  logic [SW-1:0] cand,
    output logic          cand_blocked
);
    logic          vld_q [NDST];
    logic [SW-1:0] who_q [NDST];

    for (genvar d = 0; d < NDST; d++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[d] <= 1'b0;
                who_q[d] <= '0;
            end else if (set && set_dst == DW'(d)) begin
                vld_q[d] <= 1'b1;
                who_q[d] <= set_src;
            end else if (clr && clr_dst == DW'(d)) begin
                vld_q[d] <= 1'b0;
            end
        end
    end

    assign look_hit = vld_q[look_dst];

    always_comb begin
        cand_blocked = 1'b0;
        for (int d = 0; d < NDST; d++) begin
            if (vld_q[d] && who_q[d] == cand && !(clr && clr_dst == DW'(d)))
                cand_blocked = 1'b1;
        end
    end

    p_slot_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !(set && set_dst == clr_dst)) |=> !vld_q[$past(clr_dst)]);
    p_slot_set_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> vld_q[$past(set_dst)]);

endmodule

// File: rtl/layer_arbiter.sv
module layer_arbiter
    import layer_arb_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int NDST = 4,
    parameter int TW   = 8,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int DW  = (NDST > 1) ? $clog2(NDST) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic [SW-1:0] req_src,
    input  logic [DW-1:0] req_dst,
    input  logic          req_dst_ok,
    input  logic [TW-1:0] req_hold,
    output logic          req_grant,
    input  logic          peer_rty_vld,
    input  logic [DW-1:0] peer_rty_dst,
    output logic          rty_vld,
    output logic [SW-1:0] rty_src,
    output logic [1:0]    lyr_state,
    output logic          drain
);
    lyr_state_e st_q, st_d;

    logic          q_empty, q_push, q_pop, head_match;
    logic [SW-1:0] q_head, cand;
    logic          peer_hit, peer_ok, cand_blocked;
    logic          fail, succ, refused;
    logic          tmr_load, expire;
    logic [TW-1:0] tmr_val;

    assign head_match = !q_empty && (req_src == q_head);
    assign req_grant  = req_vld && (st_q == LYR_IDLE || (st_q == LYR_RETRY && head_match));
    assign succ       = req_grant && req_dst_ok;
    assign fail       = req_grant && !req_dst_ok;
    assign refused    = req_vld && !req_grant;

    // Refused sources join the queue; a refused send joins unless it heads it.
    assign q_push  = refused || (fail && !head_match);
    assign q_pop   = succ && head_match;
    assign peer_ok = peer_rty_vld && peer_hit;
    assign cand    = q_empty ? req_src : q_head;

    assign tmr_load = req_grant || (st_q == LYR_RETRY);
    assign tmr_val  = req_grant ? req_hold : TW'(1);

    lyr_rtry_fifo #(.NSRC(NSRC), .SW(SW)) u_fifo (
        .clk(clk), .rst(rst),
        .push(q_push), .push_id(req_src), .pop(q_pop),
        .head(q_head), .empty(q_empty)
    );

    lyr_hold_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst),
        .load(tmr_load), .load_val(tmr_val),
        .run(st_q == LYR_BUSY), .expire(expire)
    );

    lyr_peer_tbl #(.NDST(NDST), .SW(SW), .DW(DW)) u_peer (
        .clk(clk), .rst(rst),
        .set(fail), .set_dst(req_dst), .set_src(req_src),
        .clr(peer_ok), .clr_dst(peer_rty_dst),
        .look_dst(peer_rty_dst), .look_hit(peer_hit),
        .cand(cand), .cand_blocked(cand_blocked)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LYR_IDLE: begin
                if (req_grant)
                    st_d = LYR_BUSY;
                else if (peer_ok && !q_empty)
                    st_d = LYR_RETRY;
            end
            LYR_BUSY: begin
                if (expire)
                    st_d = lyr_on_release(q_empty && !q_push, cand_blocked);
            end
            LYR_RETRY: st_d = LYR_BUSY;
            default:   st_d = LYR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LYR_IDLE;
        else     st_q <= st_d;
    end

    assign rty_vld   = (st_q == LYR_RETRY);
    assign rty_src   = q_head;
    assign lyr_state = st_q;
    assign drain     = (st_q != LYR_IDLE);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (lyr_state == 2'd0 && !drain && !rty_vld));
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == LYR_BUSY && !expire) |=> st_q == LYR_BUSY);
    p_no_grant_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == LYR_BUSY && req_vld) |-> !req_grant);
    p_retry_exit_r5: assert property (@(posedge clk) disable iff (rst)
        rty_vld |=> (lyr_state == 2'd1));
    p_grant_drains_r9: assert property (@(posedge clk) disable iff (rst)
        req_grant |=> drain);
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == LYR_IDLE && !req_vld && !peer_rty_vld) |=> !drain);

endmodule

// File: tb/layer_arbiter_test.sv
module layer_arbiter_test;
    localparam int NSRC = 4;
    localparam int NDST = 4;
    localparam int TW   = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_vld, req_dst_ok, peer_rty_vld;
    logic [1:0] req_src, req_dst, peer_rty_dst;
    logic [7:0] req_hold;
    logic       req_grant, rty_vld, drain;
    logic [1:0] rty_src, lyr_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    layer_arbiter #(.NSRC(NSRC), .NDST(NDST), .TW(TW)) uut (
        .clk(clk), .rst(rst),
        .req_vld(req_vld), .req_src(req_src), .req_dst(req_dst),
        .req_dst_ok(req_dst_ok), .req_hold(req_hold), .req_grant(req_grant),
        .peer_rty_vld(peer_rty_vld), .peer_rty_dst(peer_rty_dst),
        .rty_vld(rty_vld), .rty_src(rty_src),
        .lyr_state(lyr_state), .drain(drain)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // State plus drain (R9): drain must track non-idle.
    task automatic chk_st(input string tag, input int exp);
        chk(tag, lyr_state, exp);
        chk({tag, " R9 drain"}, drain, (exp != 0) ? 1 : 0);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input int src, input int dst, input bit ok, input int hold,
                        input bit exp_g, input string tag);
        req_vld = 1'b1; req_src = 2'(src); req_dst = 2'(dst);
        req_dst_ok = ok; req_hold = 8'(hold);
        #1;
        chk({tag, " grant"}, req_grant, exp_g);
        tick();
        req_vld = 1'b0; req_dst_ok = 1'b0; req_hold = '0;
    endtask

    task automatic peer(input int dst);
        peer_rty_vld = 1'b1; peer_rty_dst = 2'(dst);
        tick();
        peer_rty_vld = 1'b0;
    endtask

    task automatic t_reset_r1();
        chk_st("R1 state", 0);
        chk("R1 rty_vld", rty_vld, 0);
    endtask

    task automatic t_occupy_r2();
        send(0, 0, 1, 3, 1, "R2");
        chk_st("R2 busy c1", 1);
        tick(); tick();
        chk_st("R2 busy c3", 1);
        tick();
        chk_st("R2 idle", 0);
        send(1, 0, 1, 0, 1, "R2 zero");
        chk_st("R2 zero busy", 1);
        tick();
        chk_st("R2 zero idle", 0);
    endtask

    task automatic t_queue_r3_r4();
        send(0, 0, 1, 2, 1, "R3 first");
        send(2, 0, 1, 1, 0, "R3 reject a");
        send(1, 0, 1, 1, 0, "R3 reject b");
        chk_st("R3 retry", 2);
        chk("R3 rty_vld", rty_vld, 1);
        chk("R3 rty_src", rty_src, 2);
        send(2, 0, 1, 1, 1, "R4 resend");
        chk_st("R4 busy", 1);
        tick();
        chk_st("R4 next retry", 2);
        chk("R4 order", rty_src, 1);
        send(1, 0, 1, 1, 1, "R4 resend b");
        tick();
        chk_st("R4 drained", 0);
    endtask

    task automatic t_retry_miss_r5();
        send(0, 0, 1, 1, 1, "R5 first");
        send(3, 0, 1, 1, 0, "R5 reject");
        chk("R5 rty_src", rty_src, 3);
        send(1, 0, 1, 1, 0, "R5 other src");
        chk_st("R5 busy", 1);
        tick();
        chk_st("R5 retry again", 2);
        chk("R5 same head", rty_src, 3);
        send(3, 0, 1, 1, 1, "R5 head send");
        tick();
        chk("R5 queued other", rty_src, 1);
        send(1, 0, 1, 1, 1, "R5 other send");
        tick();
        chk_st("R5 idle", 0);
    endtask

    task automatic t_dedup_r6();
        send(0, 0, 1, 3, 1, "R6 first");
        send(1, 0, 1, 1, 0, "R6 rej 1");
        send(2, 0, 1, 1, 0, "R6 rej 2");
        send(1, 0, 1, 1, 0, "R6 rej 1 again");
        chk("R6 head", rty_src, 1);
        send(1, 0, 1, 1, 1, "R6 send 1");
        tick();
        chk("R6 second", rty_src, 2);
        send(2, 0, 1, 1, 1, "R6 send 2");
        tick();
        chk_st("R6 single entry", 0);
    endtask

    task automatic t_peer_r7_r8();
        send(2, 1, 0, 2, 1, "R7 refused");
        chk_st("R7 busy", 1);
        tick(); tick();
        chk_st("R7 held idle", 0);
        chk("R7 no retry", rty_vld, 0);
        peer(3);
        chk_st("R8 empty slot ignored", 0);
        peer(1);
        chk_st("R8 honoured", 2);
        chk("R8 rty_src", rty_src, 2);
        send(2, 1, 0, 1, 1, "R7 refused at front");
        tick();
        chk_st("R7 held again", 0);
        peer(1);
        chk("R8 retry again", rty_src, 2);
        send(2, 1, 1, 1, 1, "R8 resend ok");
        tick();
        chk_st("R8 idle", 0);
        peer(1);
        chk_st("R8 cleared slot ignored", 0);
        send(3, 0, 1, 1, 1, "R7 other");
        tick();
        chk_st("R7 no stale entry", 0);
    endtask

    initial begin
        rst = 1'b1; req_vld = 1'b0; req_src = '0; req_dst = '0;
        req_dst_ok = 1'b0; req_hold = '0; peer_rty_vld = 1'b0; peer_rty_dst = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset_r1();
        t_occupy_r2();
        t_queue_r3_r4();
        t_retry_miss_r5();
        t_dedup_r6();
        t_peer_r7_r8();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule